// File: doc/BRIEF.md
# E1 Data-Link Bit Extractor

This block sits behind an E1 frame aligner and lifts the bits of one HDLC data link out of the received 2.048 Mbit/s stream. The aligner supplies each line bit with a bit strobe, the time-slot number, the bit position within the slot, a frame-start pulse on the first bit of every frame, a flag that marks frame-alignment (FAS) frames, and an alignment-good level. The extractor passes on only the bits that the selection picks out. It emits each one on `link_bit` with a one-clock `link_valid` strobe, and the bits reach the HDLC receiver in their on-line order.

The selection works on three axes at once. The first is frame parity: even frames are the FAS frames and odd frames are the NFAS frames, and each has its own enable. The second is the time slot: a 5-bit number, or a signalling-slot override that forces slot 16. The third is an 8-bit mask over the bit positions of that slot. Three common link types come out of this selection. A common-channel signalling link uses the slot-16 override with a full mask. A V5 D/C-channel uses any other slot number. A spare-bit (Sa) link uses odd frames, slot 0 and mask `8'hF8`. The selection and the frame parity are taken on the frame-start bit, so software may rewrite the configuration at any time, and the change takes effect on a frame boundary.

The output is a stream with a valid strobe and no ready signal. Line timing cannot be stalled, so the receiver must accept every strobe. A strobe that is not taken is lost.

Top module: `e1_dl_extract`

## Requirements
- R1: While reset is low, and on the first clock after it, `link_valid` and `link_bit` are 0.
- R2: A selected line bit presented with `bit_en` high gives `link_valid` high on the next clock edge, with `link_bit` equal to that `rx_bit`.
- R3: The frame parity is taken from `fas_frame` on the frame-start bit. A value of 1 means an even (FAS) frame. `cfg_even` enables even frames and `cfg_odd` enables odd frames, and both may be set together.
- R4: With `cfg_ts16` low, only slot `cfg_slot` (0 to 31) is extracted.
- R5: With `cfg_ts16` high, slot 16 is extracted and `cfg_slot` is ignored.
- R6: Mask bit i selects `bit_pos` = i. Position 0 is the first bit of the slot on the line. Any combination of mask bits is allowed, and the extracted bits keep their line order.
- R7: With the mask all zero, or with both parity enables low, `link_valid` never asserts.
- R8: A line bit presented while `align_ok` is low produces no strobe.
- R9: The configuration is captured on the frame-start bit and holds for the whole frame. A change made mid-frame applies from the next frame start.
- R10: After reset, nothing is extracted until the first frame-start bit has been seen.
- R11: With odd frames only, slot 0 and mask `8'hF8`, the block yields the five Sa bits (positions 3 to 7) of each NFAS frame.
- R12: `link_valid` is high for exactly one clock per extracted bit, even when `bit_en` strobes come back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line-bit strobe, one clock per received bit |
| rx_bit | input | 1 | Received line bit |
| frame_start | input | 1 | Marks the first bit of a frame (with `bit_en`) |
| ts_num | input | 5 | Time slot of the current bit |
| bit_pos | input | 3 | Bit position in the slot, 0 = first on line |
| fas_frame | input | 1 | 1 for a FAS (even) frame |
| align_ok | input | 1 | Frame alignment currently held |
| cfg_even | input | 1 | Extract from even frames |
| cfg_odd | input | 1 | Extract from odd frames |
| cfg_slot | input | 5 | Programmed time slot |
| cfg_ts16 | input | 1 | Force slot 16 |
| cfg_mask | input | 8 | Bit-position mask |
| link_bit | output | 1 | Extracted bit |
| link_valid | output | 1 | One-clock strobe per extracted bit |

## Verification
Every result appears one clock edge after the `bit_en` cycle that carries it, since only one register lies between the line bit and the outputs. The bench drives inputs on falling edges and samples outputs on the next falling edge, half a cycle after the output register has updated. A monitor counts the strobes and shifts the strobed bits into a history word. After each frame the bench idles two clocks, so that the final bit has settled, and then compares the count and the history with a model of the requirements. In that model, the configuration and the parity are frozen on the frame-start bit.

// File: rtl/e1dl_pkg.sv
package e1dl_pkg;
  localparam int DL_SLOTS    = 32;
  localparam int DL_BITS     = 8;
  localparam int DL_SIG_SLOT = 16;
  localparam int TS_W        = $clog2(DL_SLOTS);
  localparam int BP_W        = $clog2(DL_BITS);

  typedef enum logic {PAR_ODD = 1'b0, PAR_EVEN = 1'b1} frame_par_t;

  typedef struct packed {
    logic              even_en;
    logic              odd_en;
    logic [TS_W-1:0]   slot;
    logic              ts16;
    logic [DL_BITS-1:0] mask;
  } sel_cfg_t;
endpackage

// File: rtl/dl_frame_ctx.sv
// Holds the selection and frame parity captured on the frame-start bit.
module dl_frame_ctx
  import e1dl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       frame_start,
  input  logic       fas_frame,
  input  sel_cfg_t   live_cfg,
  output sel_cfg_t   eff_cfg,
  output frame_par_t eff_par,
  output logic       eff_locked
);
  sel_cfg_t   shadow_q;
  frame_par_t par_q;
  logic       locked_q;
  logic       take;

  assign take = bit_en & frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      par_q    <= PAR_ODD;
      locked_q <= 1'b0;
    end else if (take) begin
      shadow_q <= live_cfg;
      par_q    <= fas_frame ? PAR_EVEN : PAR_ODD;
      locked_q <= 1'b1;
    end
  end

  // The frame-start bit itself already belongs to the new frame.
  always_comb begin
    if (take) begin
      eff_cfg    = live_cfg;
      eff_par    = fas_frame ? PAR_EVEN : PAR_ODD;
      eff_locked = 1'b1;
    end else begin
      eff_cfg    = shadow_q;
      eff_par    = par_q;
      eff_locked = locked_q;
    end
  end
endmodule

// File: rtl/dl_bit_select.sv
// Decides whether the current line bit belongs to the data link.
module dl_bit_select
  import e1dl_pkg::*;
(
  input  logic            bit_en,
  input  logic            align_ok,
  input  logic [TS_W-1:0] ts_num,
  input  logic [BP_W-1:0] bit_pos,
  input  sel_cfg_t        cfg,
  input  frame_par_t      par,
  input  logic            locked,
  output logic            hit
);
  logic [DL_BITS-1:0] pos_hot;
  logic [TS_W-1:0]    target_slot;
  logic               parity_ok, slot_ok, mask_ok;

  for (genvar g = 0; g < DL_BITS; g++) begin : g_pos
    assign pos_hot[g] = (bit_pos == BP_W'(g));
  end

  assign target_slot = cfg.ts16 ? TS_W'(DL_SIG_SLOT) : cfg.slot;
  assign parity_ok   = (par == PAR_EVEN) ? cfg.even_en : cfg.odd_en;
  assign slot_ok     = (ts_num == target_slot);
  assign mask_ok     = |(pos_hot & cfg.mask);
  assign hit         = bit_en & align_ok & locked & parity_ok & slot_ok & mask_ok;
endmodule

// File: rtl/dl_out_reg.sv
// Output register: one strobe per selected bit.
module dl_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic rx_bit,
  output logic link_bit,
  output logic link_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_valid <= 1'b0;
      link_bit   <= 1'b0;
    end else begin
      link_valid <= hit;
      link_bit   <= hit & rx_bit;
    end
  end
endmodule

// File: rtl/e1_dl_extract.sv
module e1_dl_extract
  import e1dl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            rx_bit,
  input  logic            frame_start,
  input  logic [TS_W-1:0] ts_num,
  input  logic [BP_W-1:0] bit_pos,
  input  logic            fas_frame,
  input  logic            align_ok,
  input  logic            cfg_even,
  input  logic            cfg_odd,
  input  logic [TS_W-1:0] cfg_slot,
  input  logic            cfg_ts16,
  input  logic [DL_BITS-1:0] cfg_mask,
  output logic            link_bit,
  output logic            link_valid
);
  sel_cfg_t   live_cfg, eff_cfg;
  frame_par_t eff_par;
  logic       eff_locked, hit;

  always_comb begin
    live_cfg.even_en = cfg_even;
    live_cfg.odd_en  = cfg_odd;
    live_cfg.slot    = cfg_slot;
    live_cfg.ts16    = cfg_ts16;
    live_cfg.mask    = cfg_mask;
  end

  dl_frame_ctx u_ctx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .fas_frame(fas_frame), .live_cfg(live_cfg), .eff_cfg(eff_cfg),
    .eff_par(eff_par), .eff_locked(eff_locked)
  );

  dl_bit_select u_sel (
    .bit_en(bit_en), .align_ok(align_ok), .ts_num(ts_num), .bit_pos(bit_pos),
    .cfg(eff_cfg), .par(eff_par), .locked(eff_locked), .hit(hit)
  );

  dl_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .hit(hit), .rx_bit(rx_bit),
    .link_bit(link_bit), .link_valid(link_valid)
  );
endmodule

// File: rtl/e1_dl_extract_chk.sv
module e1_dl_extract_chk
  import e1dl_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            bit_en,
  input logic            rx_bit,
  input logic            frame_start,
  input logic [TS_W-1:0] ts_num,
  input logic            align_ok,
  input logic            cfg_ts16,
  input logic [DL_BITS-1:0] cfg_mask,
  input logic            link_bit,
  input logic            link_valid
);
  logic seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (bit_en && frame_start) seen_q <= 1'b1;
  end

  p_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> (link_bit == $past(rx_bit)));
  p_ts16_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_start && cfg_ts16 && ts_num == '0) |=> !link_valid);
  p_first_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_start && !cfg_mask[0]) |=> !link_valid);
  p_empty_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && frame_start && cfg_mask == '0) |=> !link_valid);
  p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> $past(align_ok));
  p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> seen_q);
  p_one_per_bit_r12: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> $past(bit_en));
endmodule

bind e1_dl_extract e1_dl_extract_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
  .frame_start(frame_start), .ts_num(ts_num), .align_ok(align_ok),
  .cfg_ts16(cfg_ts16), .cfg_mask(cfg_mask), .link_bit(link_bit),
  .link_valid(link_valid)
);

// File: tb/e1_dl_extract_test.sv
`timescale 1ns/1ps
module e1_dl_extract_test;
  logic clk = 0, rst_n = 0;
  logic bit_en = 0, rx_bit = 0, frame_start = 0, fas_frame = 0, align_ok = 1;
  logic [4:0] ts_num = 0;
  logic [2:0] bit_pos = 0;
  logic cfg_even = 0, cfg_odd = 0, cfg_ts16 = 0;
  logic [4:0] cfg_slot = 0;
  logic [7:0] cfg_mask = 0;
  logic link_bit, link_valid;

  always #10 clk = ~clk;

  e1_dl_extract uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_start(frame_start), .ts_num(ts_num), .bit_pos(bit_pos),
    .fas_frame(fas_frame), .align_ok(align_ok), .cfg_even(cfg_even),
    .cfg_odd(cfg_odd), .cfg_slot(cfg_slot), .cfg_ts16(cfg_ts16),
    .cfg_mask(cfg_mask), .link_bit(link_bit), .link_valid(link_valid)
  );

  int errors = 0, checks = 0, fno = 0;
  bit done = 0;
  int obs_cnt = 0, exp_cnt = 0;
  logic [63:0] obs_cap = 0, exp_cap = 0;
  // model state
  bit m_seen = 0, s_even = 0, s_odd = 0, s_ts16 = 0, s_fas = 0;
  logic [4:0] s_slot = 0;
  logic [7:0] s_mask = 0;
  // values applied at a mid-frame change point
  bit n_even = 0, n_odd = 0, n_ts16 = 0;
  logic [4:0] n_slot = 0;
  logic [7:0] n_mask = 0;

  always @(negedge clk) begin
    if (rst_n && link_valid) begin
      obs_cnt <= obs_cnt + 1;
      obs_cap <= {obs_cap[62:0], link_bit};
    end
  end

  function automatic bit dat(int f, int ts, int b);
    return ((ts * 37 + b * 11 + f * 5) % 3) == 0;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    @(negedge clk);
    obs_cnt = 0; obs_cap = 0; exp_cnt = 0; exp_cap = 0;
  endtask

  task automatic settle();
    @(negedge clk); bit_en = 0; frame_start = 0;
    @(negedge clk);
  endtask

  // one frame (or its tail from first_ts); gap idle clocks between bits
  task automatic run_frame(bit fas, int first_ts, int gap, bit aln, int chg_ts);
    fno++;
    if (first_ts == 0) begin
      m_seen = 1; s_fas = fas; s_even = cfg_even; s_odd = cfg_odd;
      s_slot = cfg_slot; s_ts16 = cfg_ts16; s_mask = cfg_mask;
    end
    for (int ts = first_ts; ts < 32; ts++) begin
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        if (ts == chg_ts && b == 0) begin
          cfg_even = n_even; cfg_odd = n_odd; cfg_slot = n_slot;
          cfg_ts16 = n_ts16; cfg_mask = n_mask;
        end
        bit_en = 1; frame_start = (ts == 0 && b == 0); fas_frame = fas;
        ts_num = 5'(ts); bit_pos = 3'(b); rx_bit = dat(fno, ts, b); align_ok = aln;
        if (aln && m_seen && ((s_fas && s_even) || (!s_fas && s_odd)) &&
            ts == (s_ts16 ? 16 : int'(s_slot)) && s_mask[b]) begin
          exp_cnt++;
          exp_cap = {exp_cap[62:0], rx_bit};
        end
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); bit_en = 0; frame_start = 0;
        end
      end
    end
    settle();
    align_ok = 1;
  endtask

  task automatic set_cfg(bit e, bit o, int slot, bit t16, logic [7:0] m);
    @(negedge clk);
    cfg_even = e; cfg_odd = o; cfg_slot = 5'(slot); cfg_ts16 = t16; cfg_mask = m;
  endtask

  task automatic cmp(string req);
    chk({req, " count"}, obs_cnt, exp_cnt);
    chk({req, " bits"}, obs_cap, exp_cap);
  endtask

  task automatic t_reset();
    rst_n = 0; m_seen = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", link_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", link_valid, 0);
    chk("R1 bit after reset", link_bit, 0);
  endtask

  task automatic t_no_frame();  // R10
    set_cfg(1, 1, 5, 0, 8'hFF); clear_obs();
    run_frame(1, 3, 1, 1, 99);
    chk("R10 no frame start yet", obs_cnt, 0);
    cmp("R10");
  endtask

  task automatic t_ccs();  // R5, R2
    set_cfg(1, 1, 3, 1, 8'hFF); clear_obs();
    run_frame(1, 0, 1, 1, 99); run_frame(0, 0, 1, 1, 99);
    chk("R5 sixteen bits from slot 16", obs_cnt, 16);
    cmp("R5/R2 slot 16 override");
  endtask

  task automatic t_dchan();  // R4, R6
    set_cfg(1, 1, 7, 0, 8'b1010_0101); clear_obs();
    run_frame(1, 0, 1, 1, 99);
    chk("R4 four bits from slot 7", obs_cnt, 4);
    cmp("R6 mask order");
    set_cfg(1, 1, 31, 0, 8'h01); clear_obs();
    run_frame(0, 0, 1, 1, 99);
    cmp("R4 slot 31 first bit");
  endtask

  task automatic t_parity();  // R3
    set_cfg(1, 0, 2, 0, 8'hFF); clear_obs();
    run_frame(1, 0, 1, 1, 99); run_frame(0, 0, 1, 1, 99);
    cmp("R3 even only");
    set_cfg(0, 1, 2, 0, 8'hFF); clear_obs();
    run_frame(1, 0, 1, 1, 99); run_frame(0, 0, 1, 1, 99);
    cmp("R3 odd only");
    set_cfg(1, 1, 2, 0, 8'h3C); clear_obs();
    run_frame(1, 0, 1, 1, 99); run_frame(0, 0, 1, 1, 99);
    chk("R3 both parities", obs_cnt, 8);
    cmp("R3 both");
  endtask

  task automatic t_sa();  // R11
    set_cfg(0, 1, 0, 0, 8'hF8); clear_obs();
    for (int f = 0; f < 4; f++) run_frame(f[0] == 0, 0, 1, 1, 99);
    chk("R11 five Sa bits per NFAS frame", obs_cnt, 10);
    cmp("R11");
  endtask

  task automatic t_empty();  // R7
    set_cfg(1, 1, 4, 0, 8'h00); clear_obs();
    run_frame(1, 0, 1, 1, 99);
    chk("R7 empty mask", obs_cnt, 0);
    set_cfg(0, 0, 4, 0, 8'hFF); clear_obs();
    run_frame(0, 0, 1, 1, 99);
    chk("R7 no parity", obs_cnt, 0);
  endtask

  task automatic t_align();  // R8
    set_cfg(1, 1, 9, 0, 8'hFF); clear_obs();
    run_frame(1, 0, 1, 0, 99);
    chk("R8 alignment lost", obs_cnt, 0);
    run_frame(0, 0, 1, 1, 99);
    cmp("R8 alignment back");
  endtask

  task automatic t_midframe();  // R9
    set_cfg(1, 1, 20, 0, 8'hFF); clear_obs();
    n_even = 1; n_odd = 1; n_slot = 5'd25; n_ts16 = 0; n_mask = 8'h0F;
    run_frame(1, 0, 1, 1, 10);
    chk("R9 old slot holds for frame", obs_cnt, 8);
    clear_obs();
    run_frame(0, 0, 1, 1, 99);
    chk("R9 new slot next frame", obs_cnt, 4);
    cmp("R9");
  endtask

  task automatic t_back_to_back();  // R12
    set_cfg(1, 1, 12, 0, 8'hFF); clear_obs();
    run_frame(1, 0, 0, 1, 99);
    chk("R12 one strobe per bit", obs_cnt, 8);
    cmp("R12");
  endtask

  initial begin
    t_reset();
    t_no_frame();
    t_ccs();
    t_dchan();
    t_parity();
    t_sa();
    t_empty();
    t_align();
    t_midframe();
    t_back_to_back();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule